// File: doc/BRIEF.md
# ADC Result Register Update Controller

This block decides when the 8-bit result register of a three-input successive-approximation converter may change. A 2-bit select field picks one of three analog inputs, and the value 00 turns the converter off. While the converter is on, a countdown driven by a divided-clock tick schedules a result write at a fixed period. A status flag, "update coming", is raised a fixed number of ticks before each write. A host polls that flag before it reads.

The conversion itself is outside this block. Each input has a stub code port, and at a scheduled write the block latches the code of the input that is selected at that moment. A host read of the result register locks the register. An update that falls due during the lock is held back, and the status flag stays high until the held update is applied. The lock ends when the host signals that the read is complete, or when chip select goes high, which aborts the read. The held update is then written one clock later. A small read port returns either the result or the status byte.

Top module: `adc_update_ctrl`

## Requirements
- R1: At each write, the result register takes the 8-bit code of the selected input: select 01 takes input 0, 10 takes input 1, 11 takes input 2. Codes pass through unchanged, so FFh stays FFh and 00h stays 00h.
- R2: While select is 00, no write occurs, the status flag reads 0, and the result register keeps its last value.
- R3: When select leaves 00, the first write happens no later than FIRST_TICKS ticks afterwards. With a tick of TICK_DIV clocks, this is between (FIRST_TICKS-1)*TICK_DIV+1 and FIRST_TICKS*TICK_DIV clocks.
- R4: Writes that are not deferred follow each other exactly PERIOD_TICKS ticks apart.
- R5: A change of select while the converter is on does not alter the result register before the next scheduled write. That write uses the new input.
- R6: Before each undeferred write, the status flag rises exactly WARN_TICKS ticks ahead. It returns to 0 on the same clock edge that writes the register.
- R7: A write only happens on a cycle in which the status flag is 1.
- R8: A read cycle starts when rd_i is 1 with cs_n_i low and addr_i = 0 (the result). From then on the result register does not change. An update that falls due during the read is held, and the status flag stays at 1.
- R9: A read lock ends on a clock edge where rd_done_i is 1 or cs_n_i is 1. A held update is written on the clock edge after the one that cleared the lock. The value written is the code sampled when the update fell due.
- R10: rdata_o returns the result register when addr_i = 0 and {7'b0, status flag} when addr_i = 1. A read with addr_i = 1 does not lock the result register.
- R11: After reset, the result register is 00h, the status flag is 0, and no read lock is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_i | input | 2 | Input select (00 = off, 01/10/11 = input 0/1/2) |
| ain0_i | input | 8 | Stub conversion code for input 0 |
| ain1_i | input | 8 | Stub conversion code for input 1 |
| ain2_i | input | 8 | Stub conversion code for input 2 |
| cs_n_i | input | 1 | Host chip select, active low; high aborts a read |
| rd_i | input | 1 | Host read start strobe |
| rd_done_i | input | 1 | Host read completion strobe |
| addr_i | input | 1 | Register select: 0 result, 1 status |
| rdata_o | output | 8 | Read data |
| result_o | output | 8 | Current result register value |
| cu_o | output | 1 | Update-coming status flag |

## Verification
Faults in the countdown show up at the result port within one update period. A wrong reload value shifts the spacing of result changes. A wrong warning threshold moves the rise of the status flag relative to the write that follows it. A stuck pending or lock bit shows up within a few clocks of releasing a read. Either the held value never appears on the clock after the release, or the status flag stays at 1 after it should have dropped. Mistakes in channel selection appear in the first write after a change of select.

// File: rtl/adcu_pkg.sv
// Package: shared types and widths for the ADC result update controller.
// Assumes: three analog inputs, 8-bit result codes.
package adcu_pkg;

    localparam int RES_W  = 8;
    localparam int NUM_IN = 3;

    // Input select field encoding; OFF powers the converter down.
    typedef enum logic [1:0] {
        SEL_OFF = 2'b00,
        SEL_IN0 = 2'b01,
        SEL_IN1 = 2'b10,
        SEL_IN2 = 2'b11
    } adc_sel_e;

    // Host register select for the read port.
    typedef enum logic {
        REG_RESULT = 1'b0,
        REG_STATUS = 1'b1
    } reg_addr_e;

endpackage

// File: rtl/adcu_timebase.sv
// Timebase: divides the clock into a one-cycle tick every TICK_DIV clocks.
// Assumes: TICK_DIV >= 1; a divider of 1 yields a tick on every cycle after reset.
module adcu_timebase #(
    parameter int TICK_DIV = 200
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);

    generate
        if (TICK_DIV <= 1) begin : g_nodiv
            logic run_q;

            // Purpose: tick is high on every cycle once reset is released.
            always_ff @(posedge clk) begin
                if (!rst_n) run_q <= 1'b0;
                else        run_q <= 1'b1;
            end

            assign tick_o = run_q;
        end else begin : g_div
            localparam int DIV_W = $clog2(TICK_DIV);
            localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_DIV - 1);

            logic [DIV_W-1:0] div_q;

            // Purpose: free-running modulo-TICK_DIV prescaler.
            always_ff @(posedge clk) begin
                if (!rst_n)             div_q <= '0;
                else if (div_q == LAST) div_q <= '0;
                else                    div_q <= div_q + 1'b1;
            end

            assign tick_o = (div_q == LAST);
        end
    endgenerate

endmodule

// File: rtl/adcu_scheduler.sv
// Scheduler: counts ticks down to the next result update.
// When the converter is enabled, the count is loaded with the first-conversion latency.
// Each due point reloads it with the update period. warn_o is high during the last
// WARN_TICKS ticks before a due point.
// Assumes: WARN_TICKS < PERIOD_TICKS, 1 <= WARN_TICKS <= FIRST_TICKS.
module adcu_scheduler #(
    parameter int FIRST_TICKS  = 488,
    parameter int PERIOD_TICKS = 10000,
    parameter int WARN_TICKS   = 244
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic en_i,
    output logic due_o,
    output logic warn_o
);

    localparam int MAX_TICKS = (FIRST_TICKS > PERIOD_TICKS) ? FIRST_TICKS : PERIOD_TICKS;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);
    localparam logic [CNT_W-1:0] FIRST_LD  = CNT_W'(FIRST_TICKS);
    localparam logic [CNT_W-1:0] PERIOD_LD = CNT_W'(PERIOD_TICKS);
    localparam logic [CNT_W-1:0] WARN_LIM  = CNT_W'(WARN_TICKS);
    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // Purpose: ticks remaining until the next update; parked at first latency when off.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= FIRST_LD;
        else if (!en_i)      cnt_q <= FIRST_LD;
        else if (tick_i) begin
            if (cnt_q == ONE) cnt_q <= PERIOD_LD;
            else              cnt_q <= cnt_q - 1'b1;
        end
    end

    // Purpose: due pulse on the tick that ends the count; warning window flag.
    always_comb begin
        due_o  = en_i && tick_i && (cnt_q == ONE);
        warn_o = en_i && (cnt_q <= WARN_LIM);
    end

    AST_RELOAD_AFTER_DUE: assert property (@(posedge clk) disable iff (!rst_n)
        due_o |=> (cnt_q == PERIOD_LD)); // R4

    AST_FIRST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_i) |-> (cnt_q == FIRST_LD)); // R3

    AST_NO_DUE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> !due_o && !warn_o); // R2

endmodule

// File: rtl/adcu_result_reg.sv
// Result register with host read lock and pending update.
// A due update is written right away unless a read lock is held. Under a lock,
// the sampled code is parked, and it is written on the first clock with the lock clear.
// Assumes: due_i only pulses while en_i is high.
module adcu_result_reg #(
    parameter int RES_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             due_i,
    input  logic [RES_W-1:0] sample_i,
    input  logic             cs_n_i,
    input  logic             rd_i,
    input  logic             rd_done_i,
    input  logic             addr_res_i,
    output logic [RES_W-1:0] result_o,
    output logic             pend_o,
    output logic             wr_o
);

    logic             lock_q;
    logic             pend_q;
    logic [RES_W-1:0] pdata_q;
    logic [RES_W-1:0] result_q;

    // Purpose: read lock set by a result read start, cleared by completion or chip-select high.
    always_ff @(posedge clk) begin
        if (!rst_n)                     lock_q <= 1'b0;
        else if (cs_n_i)                lock_q <= 1'b0;
        else if (rd_done_i)             lock_q <= 1'b0;
        else if (rd_i && addr_res_i)    lock_q <= 1'b1;
    end

    // Purpose: write enable for the result register.
    always_comb begin
        wr_o = en_i && (due_i || pend_q) && !lock_q;
    end

    // Purpose: park a due sample while locked; drop it when the converter is turned off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            pdata_q <= '0;
        end else if (!en_i) begin
            pend_q  <= 1'b0;
        end else if (due_i && lock_q) begin
            pend_q  <= 1'b1;
            pdata_q <= sample_i;
        end else if (wr_o) begin
            pend_q  <= 1'b0;
        end
    end

    // Purpose: result register; a fresh due sample wins over a parked one.
    always_ff @(posedge clk) begin
        if (!rst_n)    result_q <= '0;
        else if (wr_o) result_q <= due_i ? sample_i : pdata_q;
    end

    assign result_o = result_q;
    assign pend_o   = pend_q;

    AST_FROZEN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> $stable(result_q)); // R8

    AST_CS_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_i |=> !lock_q); // R9

    AST_PEND_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(lock_q) && pend_q && en_i) |=> !pend_q); // R9

endmodule

// File: rtl/adc_update_ctrl.sv
// Top: ADC result register update controller.
// Ties together the tick timebase, the update scheduler and the locked result register.
// Provides the input mux of the stub conversion codes and the host read port.
// Assumes: select input is synchronous to clk; host strobes are single-cycle or level.
module adc_update_ctrl #(
    parameter int TICK_DIV     = 200,
    parameter int FIRST_TICKS  = 488,
    parameter int PERIOD_TICKS = 10000,
    parameter int WARN_TICKS   = 244
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel_i,
    input  logic [7:0] ain0_i,
    input  logic [7:0] ain1_i,
    input  logic [7:0] ain2_i,
    input  logic       cs_n_i,
    input  logic       rd_i,
    input  logic       rd_done_i,
    input  logic       addr_i,
    output logic [7:0] rdata_o,
    output logic [7:0] result_o,
    output logic       cu_o
);

    import adcu_pkg::*;

    adc_sel_e         sel;
    logic             en;
    logic             tick;
    logic             due;
    logic             warn;
    logic             pend;
    logic             wr;
    logic [RES_W-1:0] sample;
    logic [RES_W-1:0] res;

    // Purpose: decode the select field into an enable.
    always_comb begin
        sel = adc_sel_e'(sel_i);
        en  = (sel != SEL_OFF);
    end

    // Purpose: route the stub code of the selected input.
    always_comb begin
        unique case (sel)
            SEL_IN0: sample = ain0_i;
            SEL_IN1: sample = ain1_i;
            SEL_IN2: sample = ain2_i;
            default: sample = '0;
        endcase
    end

    adcu_timebase #(
        .TICK_DIV (TICK_DIV)
    ) u_tb (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    adcu_scheduler #(
        .FIRST_TICKS  (FIRST_TICKS),
        .PERIOD_TICKS (PERIOD_TICKS),
        .WARN_TICKS   (WARN_TICKS)
    ) u_sched (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .en_i   (en),
        .due_o  (due),
        .warn_o (warn)
    );

    adcu_result_reg #(
        .RES_W (RES_W)
    ) u_res (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en),
        .due_i      (due),
        .sample_i   (sample),
        .cs_n_i     (cs_n_i),
        .rd_i       (rd_i),
        .rd_done_i  (rd_done_i),
        .addr_res_i (reg_addr_e'(addr_i) == REG_RESULT),
        .result_o   (res),
        .pend_o     (pend),
        .wr_o       (wr)
    );

    // Purpose: status flag and host read data mux.
    always_comb begin
        cu_o     = warn || (en && pend);
        result_o = res;
        if (reg_addr_e'(addr_i) == REG_STATUS) rdata_o = {{(RES_W-1){1'b0}}, cu_o};
        else                                   rdata_o = res;
    end

    AST_CU_AT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> cu_o); // R7

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_OFF) |=> $stable(result_o)); // R2

    AST_CU_DROPS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && due) |=> !cu_o); // R6

endmodule

// File: tb/sim_adc_update_ctrl.sv
// Directed bench for adc_update_ctrl with short timing parameters.
module sim_adc_update_ctrl;

    localparam int TD = 2;
    localparam int FL = 20;
    localparam int PT = 40;
    localparam int WT = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel = 2'b00;
    logic [7:0] a0, a1, a2;
    logic       cs_n = 1'b1;
    logic       rd = 1'b0;
    logic       rd_done = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] rdata_o, result_o;
    logic       cu_o;

    always #2.5 clk = ~clk;

    adc_update_ctrl #(
        .TICK_DIV (TD), .FIRST_TICKS (FL), .PERIOD_TICKS (PT), .WARN_TICKS (WT)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .sel_i (sel),
        .ain0_i (a0), .ain1_i (a1), .ain2_i (a2),
        .cs_n_i (cs_n), .rd_i (rd), .rd_done_i (rd_done), .addr_i (addr),
        .rdata_o (rdata_o), .result_o (result_o), .cu_o (cu_o)
    );

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor state
    int         ncyc = 0;
    int         wr_cnt = 0;
    int         last_wr = 0;
    int         cu_rise = 0;
    logic [7:0] last_res = 8'h00;
    bit         prev_cu = 1'b0;
    bit         hold = 1'b0;
    bit         in_lock = 1'b0;
    logic [7:0] hv = 8'h00;

    // Monitor: detects writes, checks channel value, warning lead and flag drop.
    always @(negedge clk) begin
        if (rst_n) begin
            if (result_o !== last_res) begin
                logic [7:0] expv;
                wr_cnt++;
                last_wr = ncyc;
                check(prev_cu == 1'b1, "R7 flag before write", int'(prev_cu), 1);
                check(cu_o == 1'b0, "R6 flag clears at write", int'(cu_o), 0);
                check(sel != 2'b00, "R2 write while off", int'(sel), 1);
                if (!in_lock)
                    check(ncyc - cu_rise == WT*TD, "R6 warning lead", ncyc - cu_rise, WT*TD);
                if (!hold) begin
                    expv = (sel == 2'b01) ? a0 : (sel == 2'b10) ? a1 : a2;
                    check(result_o == expv, "R1 selected code", int'(result_o), int'(expv));
                end
                last_res = result_o;
            end
            if (cu_o && !prev_cu) cu_rise = ncyc;
            prev_cu = cu_o;
        end
        ncyc++;
        a0 <= hold ? hv : 8'(ncyc);
        a1 <= hold ? hv : 8'(ncyc + 85);
        a2 <= hold ? hv : 8'(ncyc + 170);
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wait_write(input string req);
        int w = wr_cnt;
        int t = 0;
        while (wr_cnt == w && t < 400) begin step(1); t++; end
        check(wr_cnt != w, req, wr_cnt, w + 1);
    endtask

    task automatic wait_cu_rise();
        int t = 0;
        while (cu_o && t < 400) begin step(1); t++; end
        while (!cu_o && t < 400) begin step(1); t++; end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(5);
        rst_n = 1'b1;
        step(1);
        check(result_o == 8'h00, "R11 result reset", int'(result_o), 0);
        check(cu_o == 1'b0, "R11 flag reset", int'(cu_o), 0);
        check(rdata_o == 8'h00, "R11 read data reset", int'(rdata_o), 0);
    endtask

    task automatic t_off();
        int w = wr_cnt;
        sel = 2'b00;
        step(200);
        check(wr_cnt == w, "R2 no writes while off", wr_cnt, w);
        check(cu_o == 1'b0, "R2 flag low while off", int'(cu_o), 0);
    endtask

    task automatic t_first();
        int n0;
        int lat;
        sel = 2'b01;
        n0 = ncyc - 1;
        wait_write("R3 first write seen");
        lat = last_wr - n0;
        check(lat >= (FL-1)*TD+1 && lat <= FL*TD, "R3 first latency", lat, FL*TD);
    endtask

    task automatic t_period();
        int w;
        wait_write("R4 write seen");
        w = last_wr;
        wait_write("R4 next write seen");
        check(last_wr - w == PT*TD, "R4 period", last_wr - w, PT*TD);
    endtask

    task automatic t_sel_change();
        int w;
        int c;
        logic [7:0] r;
        wait_write("R5 write seen");
        w = last_wr;
        step(20);
        sel = 2'b11;
        r = result_o;
        c = wr_cnt;
        step(30);
        check(result_o == r && wr_cnt == c, "R5 no change before boundary", int'(result_o), int'(r));
        wait_write("R5 boundary write");
        check(last_wr - w == PT*TD, "R5 change waits for boundary", last_wr - w, PT*TD);
        sel = 2'b10;
        wait_write("R5 second change");
    endtask

    // Lock a read across a due point, then release by chip select or completion strobe.
    task automatic t_lock(input bit by_cs, input logic [7:0] v_due, input logic [7:0] v_late);
        int c;
        wait_cu_rise();
        in_lock = 1'b1;
        hold = 1'b1;
        hv = v_due;
        cs_n = 1'b0; rd = 1'b1; addr = 1'b0;
        step(1);
        rd = 1'b0;
        c = wr_cnt;
        step(20);
        check(wr_cnt == c, "R8 frozen during read", wr_cnt, c);
        check(cu_o == 1'b1, "R8 flag held while pending", int'(cu_o), 1);
        hv = v_late;
        step(10);
        check(wr_cnt == c, "R8 still frozen", wr_cnt, c);
        if (by_cs) cs_n = 1'b1;
        else       rd_done = 1'b1;
        step(1);
        rd_done = 1'b0;
        cs_n = 1'b1;
        check(wr_cnt == c, "R9 no write on clearing edge", wr_cnt, c);
        step(1);
        check(wr_cnt == c + 1, "R9 write one clock after release", wr_cnt, c + 1);
        check(result_o == v_due, "R9 R1 held code written", int'(result_o), int'(v_due));
        check(cu_o == 1'b0, "R9 flag drops on held write", int'(cu_o), 0);
        hold = 1'b0;
        step(1);
        in_lock = 1'b0;
    endtask

    task automatic t_readback();
        wait_cu_rise();
        cs_n = 1'b0; addr = 1'b1; rd = 1'b1;
        step(1);
        check(rdata_o == 8'h01, "R10 status read", int'(rdata_o), 1);
        wait_write("R10 status read does not lock");
        addr = 1'b0; rd = 1'b0;
        step(1);
        check(rdata_o == last_res, "R10 result read", int'(rdata_o), int'(last_res));
        cs_n = 1'b1;
    endtask

    task automatic t_disable_mid();
        int c;
        logic [7:0] r;
        wait_cu_rise();
        sel = 2'b00;
        step(1);
        check(cu_o == 1'b0, "R2 flag drops when off", int'(cu_o), 0);
        r = result_o;
        c = wr_cnt;
        step(120);
        check(wr_cnt == c, "R2 no writes after off", wr_cnt, c);
        check(result_o == r, "R2 result retained", int'(result_o), int'(r));
    endtask

    initial begin
        t_reset();
        t_off();
        t_first();
        t_period();
        t_sel_change();
        t_lock(1'b1, 8'hFF, 8'h3C);
        t_lock(1'b0, 8'h00, 8'h55);
        t_readback();
        t_disable_mid();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", nchk, nfail);
            $finish;
        end
    end

endmodule